// File: doc/BRIEF.md
# Stereo Audio Serial Output Port

This block turns a stream of stereo sample pairs into a single serial data line. The line is framed by a bit clock and a frame clock, and each frame holds one left word and one right word. Each word is 24 bits in two's complement and is sent most significant bit first. The port can work as the clock master or as a slave. As master, it makes both clocks from its own clock input. A two-bit speed mode sets the frame length, and an optional pre-divide by two halves every rate. As slave, it follows a bit clock and a frame clock supplied from outside. It supports the left-justified frame format and the I2S frame format.

The block runs from one clock, `clk`, which runs at twice the master-clock rate. The master clock is the clock that the external rate ratios refer to. Sample pairs arrive through a valid/ready handshake into a one-pair holding register. A held pair goes on the line from the start of the next left half-frame. If no new pair arrives, the last pair is sent again. The external clocks in slave mode are re-timed into `clk`, so they must be much slower than `clk`.

Top module: `audio_ser_port`

## Requirements
- R1: In master mode with pre-divide off, one frame-clock period lasts 256, 128 or 64 master-clock periods (512, 256 or 128 `clk` cycles) for speed codes 00, 01 and 10. Each frame holds 64 bit-clock periods. The frame clock changes only at a bit-clock falling edge.
- R2: With `cfg_pre_div2` set in master mode, both generated clock periods are twice their R1 values.
- R3: In left-justified format, the frame clock is high for the left word. The MSB of a word is on the data line in the first bit slot after the frame-clock edge. The next 23 slots carry the other bits in order, down to bit 0.
- R4: In I2S format, the frame clock is low for the left word. The first bit slot after the frame-clock edge carries 0, and the MSB follows in the second slot.
- R5: `ser_data` changes only after a falling bit-clock edge. It is stable while the bit clock is high, so a receiver can sample it on the rising edge.
- R6: Half-frame slots after bit 0 of the word are driven as 0. This holds for half-frames of 32 slots and of 64 slots.
- R7: With a 16-slot half-frame (32 bit clocks per frame), only the word bits that fit are sent, starting from the MSB. That is 16 bits in left-justified format and 15 bits in I2S format.
- R8: Speed code 11 runs with single-speed timing (512 `clk` cycles per frame) and sets `cfg_err` to 1. `cfg_err` is also 1 in slave mode when `cfg_pre_div2` is 1. Otherwise it is 0.
- R9: `smp_ready` is 1 while the holding register is empty. After a pair is accepted, `smp_ready` is 0 until the next left half-frame starts. At that point the accepted pair goes on the line. If no new pair is accepted, the previous pair is sent again.
- R10: While `rst_n` is low, `ser_data`, `bclk_out`, `fclk_out` and `cfg_err` are all 0. After reset, `smp_ready` is 1.
- R11: In slave mode, `bclk_out` and `fclk_out` stay 0. The data is framed by `bclk_in` and `fclk_in`, with 16, 32 or 64 bit slots per half-frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, at twice the master-clock rate |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_master | input | 1 | 1 = generate the clocks, 0 = follow external clocks |
| cfg_i2s | input | 1 | 1 = I2S format, 0 = left-justified format |
| cfg_speed | input | 2 | Speed code: 00 single, 01 double, 10 quad, 11 reserved |
| cfg_pre_div2 | input | 1 | Divide the master clock by two before everything else |
| smp_valid | input | 1 | A sample pair is offered |
| smp_ready | output | 1 | The holding register is empty |
| smp_left | input | 24 | Left sample, two's complement |
| smp_right | input | 24 | Right sample, two's complement |
| bclk_in | input | 1 | External bit clock (slave mode) |
| fclk_in | input | 1 | External frame clock (slave mode) |
| bclk_out | output | 1 | Generated bit clock (master mode) |
| fclk_out | output | 1 | Generated frame clock (master mode) |
| ser_data | output | 1 | Serial sample data |
| cfg_err | output | 1 | Invalid configuration flag |

## Verification
The master-mode checks cover four combinations of speed code, pre-divide and format. They use asymmetric left and right words, such as a lone MSB against an alternating pattern. This lets a bit-order error, a channel swap, a lost I2S delay slot or a wrong divide ratio show up as a distinct mismatch. Each master run sends one pair twice and then replaces it, which shows both the repeat behaviour and the handshake. Slave runs at 16 and 64 slots per half-frame show truncation and zero padding on externally timed frames. The reserved speed code is checked for its flag and for its timing.

// File: rtl/aso_pkg.sv
`timescale 1ns/1ps
package aso_pkg;

  typedef enum logic [1:0] {
    SPD_SINGLE = 2'b00,
    SPD_DOUBLE = 2'b01,
    SPD_QUAD   = 2'b10,
    SPD_RSVD   = 2'b11
  } speed_e;

  // clk runs at twice the master clock. A bit period is (frame / 64) master
  // clocks, so its half in clk cycles is 4, 2 or 1, doubled by the pre-divide.
  function automatic int unsigned bclk_half_cycles(logic [1:0] spd, logic div2);
    int unsigned base;
    case (speed_e'(spd))
      SPD_DOUBLE: base = 2;
      SPD_QUAD:   base = 1;
      default:    base = 4;
    endcase
    return div2 ? (base << 1) : base;
  endfunction

  // Bit at position idx counted from the MSB; outside the word it is 0.
  function automatic logic word_bit(logic [63:0] word, int width, int idx);
    if (idx < 0 || idx >= width) return 1'b0;
    return word[width - 1 - idx];
  endfunction

endpackage

// File: rtl/aso_clkgen.sv
`timescale 1ns/1ps
module aso_clkgen
  import aso_pkg::*;
#(
  parameter int unsigned SLOTS_PER_FRAME = 64,
  parameter int unsigned HALF_W          = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       fmt_i2s,
  input  logic [1:0] speed,
  input  logic       pre_div2,
  output logic       bclk_q,
  output logic       fclk_q,
  output logic       fall_evt,
  output logic       fclk_nxt
);
  localparam int unsigned FC_W = $clog2(SLOTS_PER_FRAME);

  logic [HALF_W-1:0] hc;
  logic [HALF_W-1:0] half_m1;
  logic [FC_W-1:0]   fc;
  logic [FC_W-1:0]   fc_nxt;
  logic              tick;

  always_comb begin
    half_m1  = HALF_W'(bclk_half_cycles(speed, pre_div2) - 1);
    tick     = en && (hc == half_m1);
    fall_evt = tick && bclk_q;
    fc_nxt   = fc + 1'b1;
    // first half of the frame is left: high for left-justified, low for I2S
    fclk_nxt = fmt_i2s ^ ~fc_nxt[FC_W-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      hc     <= '0;
      bclk_q <= 1'b0;
      fclk_q <= 1'b0;
      fc     <= '1;
    end else if (tick) begin
      hc     <= '0;
      bclk_q <= ~bclk_q;
      if (bclk_q) begin
        fc     <= fc_nxt;
        fclk_q <= fclk_nxt;
      end
    end else begin
      hc <= hc + 1'b1;
    end
  end

  AST_FCLK_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (fclk_q != $past(fclk_q)) |-> (!bclk_q && $past(bclk_q))); // R1

endmodule

// File: rtl/aso_edge_sync.sv
`timescale 1ns/1ps
module aso_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_in,
  input  logic fclk_in,
  output logic fall_evt,
  output logic fclk_lvl
);
  logic [SYNC_STAGES-1:0] b_sync;
  logic [SYNC_STAGES-1:0] f_sync;
  logic                   b_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_sync <= '0;
      f_sync <= '0;
      b_last <= 1'b0;
    end else begin
      b_sync <= {b_sync[SYNC_STAGES-2:0], bclk_in};
      f_sync <= {f_sync[SYNC_STAGES-2:0], fclk_in};
      b_last <= b_sync[SYNC_STAGES-1];
    end
  end

  assign fall_evt = b_last & ~b_sync[SYNC_STAGES-1];
  assign fclk_lvl = f_sync[SYNC_STAGES-1];

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> !fall_evt); // R11

endmodule

// File: rtl/aso_serializer.sv
`timescale 1ns/1ps
module aso_serializer
  import aso_pkg::*;
#(
  parameter int unsigned SAMPLE_W       = 24,
  parameter int unsigned MAX_HALF_SLOTS = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fmt_i2s,
  input  logic                fall_evt,
  input  logic                fclk_lvl,
  input  logic                smp_valid,
  output logic                smp_ready,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  output logic                ser_data
);
  localparam int unsigned SLOT_W = $clog2(MAX_HALF_SLOTS + 1);
  localparam logic [SLOT_W-1:0] SLOT_MAX = SLOT_W'(MAX_HALF_SLOTS);
  localparam int unsigned PAD_W = 64 - SAMPLE_W;

  logic                fclk_last;
  logic                primed;
  logic [SLOT_W-1:0]   slot_cnt;
  logic [SLOT_W-1:0]   slot_nxt;
  logic [SAMPLE_W-1:0] cur_l, cur_r, pend_l, pend_r;
  logic                full;
  logic                new_half;
  logic                left_now;
  logic                load;
  logic                accept;
  logic [SAMPLE_W-1:0] word;
  int                  bit_idx;
  logic                bit_nxt;

  always_comb begin
    new_half = fclk_lvl ^ fclk_last;
    left_now = fmt_i2s ^ fclk_lvl;
    load     = fall_evt && new_half && left_now && full;
    accept   = smp_valid && !full;
    if (new_half)                 slot_nxt = '0;
    else if (slot_cnt == SLOT_MAX) slot_nxt = slot_cnt;
    else                          slot_nxt = slot_cnt + 1'b1;
    bit_idx  = int'(slot_nxt) - (fmt_i2s ? 1 : 0);
    if (left_now) word = load ? pend_l : cur_l;
    else          word = cur_r;
    bit_nxt  = (primed || new_half) ?
               word_bit({{PAD_W{1'b0}}, word}, SAMPLE_W, bit_idx) : 1'b0;
  end

  assign smp_ready = !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fclk_last <= 1'b0;
      primed    <= 1'b0;
      slot_cnt  <= '0;
      cur_l     <= '0;
      cur_r     <= '0;
      pend_l    <= '0;
      pend_r    <= '0;
      full      <= 1'b0;
      ser_data  <= 1'b0;
    end else begin
      if (accept) begin
        pend_l <= smp_left;
        pend_r <= smp_right;
        full   <= 1'b1;
      end
      if (fall_evt) begin
        fclk_last <= fclk_lvl;
        primed    <= primed | new_half;
        slot_cnt  <= slot_nxt;
        ser_data  <= bit_nxt;
        if (load) begin
          cur_l <= pend_l;
          cur_r <= pend_r;
          full  <= 1'b0;
        end
      end
    end
  end

  AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_data != $past(ser_data)) |-> $past(fall_evt)); // R5
  AST_I2S_GAP_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_evt && new_half && fmt_i2s) |=> !ser_data); // R4
  AST_LOAD_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> smp_ready); // R9

endmodule

// File: rtl/audio_ser_port.sv
`timescale 1ns/1ps
module audio_ser_port
  import aso_pkg::*;
#(
  parameter int unsigned SAMPLE_W        = 24,
  parameter int unsigned SLOTS_PER_FRAME = 64,
  parameter int unsigned MAX_HALF_SLOTS  = 64,
  parameter int unsigned SYNC_STAGES     = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_master,
  input  logic                cfg_i2s,
  input  logic [1:0]          cfg_speed,
  input  logic                cfg_pre_div2,
  input  logic                smp_valid,
  output logic                smp_ready,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  input  logic                bclk_in,
  input  logic                fclk_in,
  output logic                bclk_out,
  output logic                fclk_out,
  output logic                ser_data,
  output logic                cfg_err
);
  localparam int unsigned HALF_W = 4;

  logic m_fall, m_fclk_nxt;
  logic s_fall, s_fclk;
  logic fall_evt, fclk_lvl;

  aso_clkgen #(
    .SLOTS_PER_FRAME(SLOTS_PER_FRAME),
    .HALF_W         (HALF_W)
  ) u_clkgen (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (cfg_master),
    .fmt_i2s (cfg_i2s),
    .speed   (cfg_speed),
    .pre_div2(cfg_pre_div2),
    .bclk_q  (bclk_out),
    .fclk_q  (fclk_out),
    .fall_evt(m_fall),
    .fclk_nxt(m_fclk_nxt)
  );

  aso_edge_sync #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .bclk_in (bclk_in),
    .fclk_in (fclk_in),
    .fall_evt(s_fall),
    .fclk_lvl(s_fclk)
  );

  assign fall_evt = cfg_master ? m_fall     : s_fall;
  assign fclk_lvl = cfg_master ? m_fclk_nxt : s_fclk;

  aso_serializer #(
    .SAMPLE_W      (SAMPLE_W),
    .MAX_HALF_SLOTS(MAX_HALF_SLOTS)
  ) u_ser (
    .clk      (clk),
    .rst_n    (rst_n),
    .fmt_i2s  (cfg_i2s),
    .fall_evt (fall_evt),
    .fclk_lvl (fclk_lvl),
    .smp_valid(smp_valid),
    .smp_ready(smp_ready),
    .smp_left (smp_left),
    .smp_right(smp_right),
    .ser_data (ser_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_err <= 1'b0;
    else        cfg_err <= (cfg_speed == SPD_RSVD) || (!cfg_master && cfg_pre_div2);
  end

  AST_RESERVED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_speed == 2'b11) |=> cfg_err); // R8
  AST_SLAVE_CLKS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_master |-> (!bclk_out && !fclk_out)); // R11

endmodule

// File: tb/audio_ser_port_tb.sv
`timescale 1ns/1ps
module audio_ser_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_master = 1'b1, cfg_i2s = 1'b0, cfg_pre_div2 = 1'b0;
  logic [1:0]  cfg_speed = 2'b00;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [23:0] smp_left = '0, smp_right = '0;
  logic        bclk_in = 1'b0, fclk_in = 1'b0;
  logic        bclk_out, fclk_out, ser_data, cfg_err;

  int checks = 0, errors = 0;
  int r5_bad = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  audio_ser_port u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_i2s(cfg_i2s),
    .cfg_speed(cfg_speed), .cfg_pre_div2(cfg_pre_div2), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_left(smp_left), .smp_right(smp_right),
    .bclk_in(bclk_in), .fclk_in(fclk_in), .bclk_out(bclk_out),
    .fclk_out(fclk_out), .ser_data(ser_data), .cfg_err(cfg_err)
  );

  // R5: every data change must be followed by a low bit clock
  always @(ser_data) begin
    if (mon_en) begin
      #1;
      if (bclk_out !== 1'b0) r5_bad++;
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic exp_bit(logic [23:0] w, int s, bit i2s);
    int idx = i2s ? s - 1 : s;
    if (idx < 0 || idx > 23) return 1'b0;
    return w[23 - idx];
  endfunction

  task automatic do_reset(bit mst, bit i2s, logic [1:0] spd, bit dv);
    @(negedge clk);
    rst_n = 1'b0; mon_en = 1'b0;
    cfg_master = mst; cfg_i2s = i2s; cfg_speed = spd; cfg_pre_div2 = dv;
    bclk_in = 1'b0; fclk_in = i2s;  // right-channel level
    smp_valid = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic push(logic [23:0] l, logic [23:0] r);
    forever begin
      @(negedge clk);
      if (smp_ready) begin
        smp_valid = 1'b1; smp_left = l; smp_right = r;
        @(negedge clk);
        smp_valid = 1'b0;
        break;
      end
    end
  endtask

  task automatic wait_left_start(bit i2s, output logic first);
    logic pol = i2s ? 1'b0 : 1'b1;
    logic prev = fclk_out;
    forever begin
      @(posedge bclk_out); #1;
      if (fclk_out == pol && prev != pol) break;
      prev = fclk_out;
    end
    first = ser_data;
  endtask

  task automatic capture_master(bit i2s, output logic [127:0] bits);
    logic b;
    bits = '0;
    wait_left_start(i2s, b);   // may still carry an older pair
    wait_left_start(i2s, b);
    bits[0] = b;
    for (int s = 1; s < 64; s++) begin
      @(posedge bclk_out); #1;
      bits[s] = ser_data;
    end
  endtask

  task automatic check_frame(logic [127:0] bits, logic [23:0] l, logic [23:0] r,
                             bit i2s, int half, string tag);
    for (int h = 0; h < 2; h++) begin
      int mism = 0;
      logic [127:0] act = '0, exp = '0;
      for (int s = 0; s < half; s++) begin
        act[s] = bits[h*half + s];
        exp[s] = exp_bit(h == 0 ? l : r, s, i2s);
        if (act[s] !== exp[s]) mism++;
      end
      chk(mism == 0, tag, h == 0 ? "left half slots" : "right half slots",
          longint'(act[63:0]), longint'(exp[63:0]));
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst_n = 1'b0;
    cfg_master = 1'b1; cfg_speed = 2'b11;
    repeat (4) @(negedge clk);
    chk(ser_data == 0 && bclk_out == 0 && fclk_out == 0 && cfg_err == 0, "R10",
        "outputs during reset", {ser_data, bclk_out, fclk_out, cfg_err}, 0);
    do_reset(1'b1, 1'b0, 2'b00, 1'b0);
    @(negedge clk);
    chk(smp_ready == 1'b1, "R10", "ready after reset", smp_ready, 1);
  endtask

  task automatic t_master(logic [1:0] spd, bit dv, bit i2s,
                          logic [23:0] al, logic [23:0] ar,
                          logic [23:0] bl, logic [23:0] br);
    longint t0, f_per, b_per, f_exp;
    int mclk_frame;
    logic [127:0] bits;
    string dtag = i2s ? "R4 R6" : "R3 R6";
    string ptag = dv ? "R2" : "R1";
    do_reset(1'b1, i2s, spd, dv);
    mclk_frame = (spd == 2'b01) ? 128 : (spd == 2'b10) ? 64 : 256;
    f_exp = longint'(4 * 2 * mclk_frame * (dv ? 2 : 1));
    @(posedge fclk_out); t0 = $time;
    @(posedge fclk_out); f_per = $time - t0;
    @(posedge bclk_out); t0 = $time;
    @(posedge bclk_out); b_per = $time - t0;
    chk(f_per == f_exp, ptag, "frame clock period ns", f_per, f_exp);
    chk(b_per == f_exp / 64, ptag, "bit clock period ns", b_per, f_exp / 64);
    r5_bad = 0; mon_en = 1'b1;
    push(al, ar);
    chk(smp_ready == 1'b0, "R9", "ready low while pair held", smp_ready, 0);
    capture_master(i2s, bits);
    check_frame(bits, al, ar, i2s, 32, dtag);
    capture_master(i2s, bits);
    check_frame(bits, al, ar, i2s, 32, "R9 repeat");
    push(bl, br);
    capture_master(i2s, bits);
    check_frame(bits, bl, br, i2s, 32, "R9 replace");
    mon_en = 1'b0;
    chk(r5_bad == 0, "R5", "data changes while bit clock high", r5_bad, 0);
  endtask

  task automatic t_reserved;
    longint t0, f_per;
    do_reset(1'b1, 1'b0, 2'b11, 1'b0);
    repeat (3) @(negedge clk);
    chk(cfg_err == 1'b1, "R8", "flag for speed code 11", cfg_err, 1);
    @(posedge fclk_out); t0 = $time;
    @(posedge fclk_out); f_per = $time - t0;
    chk(f_per == 2048, "R8", "frame period ns for speed code 11", f_per, 2048);
    do_reset(1'b0, 1'b0, 2'b00, 1'b1);
    repeat (3) @(negedge clk);
    chk(cfg_err == 1'b1, "R8", "flag for pre-divide in slave mode", cfg_err, 1);
    do_reset(1'b0, 1'b0, 2'b00, 1'b0);
    repeat (3) @(negedge clk);
    chk(cfg_err == 1'b0, "R8", "no flag for valid slave setup", cfg_err, 0);
  endtask

  task automatic t_slave(bit i2s, int half, logic [23:0] l, logic [23:0] r, string tag);
    logic [127:0] bits = '0;
    logic lpol = i2s ? 1'b0 : 1'b1;
    bit clk_bad = 1'b0;
    do_reset(1'b0, i2s, 2'b00, 1'b0);
    push(l, r);
    for (int f = 0; f < 2; f++)
      for (int h = 0; h < 2; h++)
        for (int s = 0; s < half; s++) begin
          @(negedge clk);
          bclk_in = 1'b0;
          if (s == 0) fclk_in = (h == 0) ? lpol : ~lpol;
          repeat (7) @(negedge clk);
          bclk_in = 1'b1;
          repeat (7) @(negedge clk);
          if (bclk_out !== 1'b0 || fclk_out !== 1'b0) clk_bad = 1'b1;
          if (f == 1) bits[h*half + s] = ser_data;
        end
    chk(!clk_bad, "R11", "generated clocks low in slave mode", clk_bad, 0);
    check_frame(bits, l, r, i2s, half, tag);
  endtask

  initial begin
    t_reset();
    t_master(2'b00, 1'b0, 1'b0, 24'h800000, 24'h555555, 24'h123456, 24'hFEDCBA);
    t_master(2'b01, 1'b1, 1'b1, 24'hC00001, 24'h0F0F0F, 24'h7FFFFF, 24'h000001);
    t_master(2'b10, 1'b0, 1'b0, 24'hA5A5A5, 24'h3C3C3C, 24'h000001, 24'h800000);
    t_master(2'b10, 1'b1, 1'b1, 24'h81FF18, 24'h2468AC, 24'hFFFFFF, 24'h000000);
    t_reserved();
    t_slave(1'b0, 16, 24'hABCDEF, 24'h13579B, "R7 R11");
    t_slave(1'b1, 16, 24'hABCDEF, 24'h13579B, "R7 R4");
    t_slave(1'b0, 64, 24'h9ACE01, 24'h400003, "R6 R11");
    t_slave(1'b1, 32, 24'hF00F0F, 24'h0FF0F1, "R4 R11");
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule